// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides, for each frame arriving on a byte-wide receive stream, whether the frame is kept or dropped, based only on its 48-bit destination address. Bytes arrive one per clock qualified by a valid strobe. A start marker flags the first byte and an end marker flags the last. The filter captures the first six bytes. One clock after the sixth byte it produces a single-cycle verdict: an accept flag and a reason code that tells which rule let the frame through.

Software programs the filter through a small write-only register port. The programmable items are:
- the station address, split little-endian across two registers, with a valid flag and a match-enable flag;
- a 64-bit multicast hash table held in two words;
- a broadcast enable and a copy-all (promiscuous) enable;
- a per-channel unicast enable mask, of which channel 0 gates station-address matches.

Multicast frames are looked up in the hash table at an index taken from a CRC-32 over the destination address.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `res_valid` is 0 and all configuration is cleared, so every complete frame is rejected with reason 0.
- R2: Register 0 holds destination bytes 3..0, with byte 0 (the first byte on the wire) in bits 7:0 and byte 3 in bits 31:24. Register 1 holds byte 4 in bits 7:0 and byte 5 in bits 15:8. A destination equal to the station address gives reason 1 (unicast) when the conditions of R3 hold.
- R3: A unicast match counts only when register 1 bit 16 (address valid), register 1 bit 17 (match enable) and register 5 bit 0 (channel 0 unicast enable) are all 1.
- R4: A destination of all ones gives reason 2 (broadcast) when register 4 bit 0 is 1.
- R5: A destination whose byte 0 has bit 0 set, and which is not all ones, is multicast. Its hash index is bits 31:26 of a CRC-32 register. The register uses the reflected polynomial 0xEDB88320, is seeded with all ones, takes the 48 address bits least significant bit first in byte order, and gets no final inversion. Index i selects bit i of register 2 for i < 32 and bit i-32 of register 3 otherwise. A set bit gives reason 3, so an all-zero table rejects every multicast frame.
- R6: Register 4 bit 1 (copy-all) accepts any complete frame with reason 4. The priority when several rules apply is unicast, then broadcast, then multicast hash, then copy-all.
- R7: `res_valid` pulses for exactly one cycle, in the cycle after the sixth byte is taken. Bytes after the sixth produce no further result.
- R8: A frame whose end marker comes on byte 1 to 5 yields a one-cycle result one clock after that byte, with accept 0 and reason 0, even when copy-all is set.
- R9: A start marker in the middle of a frame abandons the bytes collected so far without a result, and collection restarts from that byte.
- R10: `res_accept` is 1 exactly when `res_reason` is not 0.
- R11: Only bit 0 of the unicast channel mask affects filtering; the other mask bits do not enable unicast matches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Register index: 0 station low bytes, 1 station high bytes and flags, 2 hash low, 3 hash high, 4 control, 5 channel mask |
| cfg_wdata | input | 32 | Configuration write data |
| rx_valid | input | 1 | Receive byte qualifier |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_data | input | 8 | Receive byte |
| res_valid | output | 1 | One-cycle verdict strobe |
| res_accept | output | 1 | Frame accepted |
| res_reason | output | 3 | 0 reject, 1 unicast, 2 broadcast, 3 multicast hash, 4 copy-all |

## Verification
Assertions check the following on every cycle:
- a verdict follows a final or short byte strobe one clock earlier;
- a short frame always produces a reject;
- accept agrees with a non-zero reason;
- a broadcast or unicast reason only appears when the matching enables were set;
- the byte counter stays in range.

Only the bench's scenarios can show that the right rule wins. That covers the little-endian address layout, the CRC-derived hash index for each of the 64 table bits, the priority order across all enable combinations, and that a restarted frame or trailing payload produces no extra verdict.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
  localparam int unsigned ADDR_BYTES = 6;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned ADDR_W     = ADDR_BYTES * BYTE_W;
  localparam int unsigned HEAD_W     = (ADDR_BYTES - 1) * BYTE_W;
  localparam int unsigned HASH_W     = 64;
  localparam int unsigned HASH_IDX_W = $clog2(HASH_W);
  localparam int unsigned CRC_W      = 32;
  localparam int unsigned POS_W      = $clog2(ADDR_BYTES + 1);
  localparam int unsigned CFG_AW     = 3;
  localparam int unsigned CFG_DW     = 32;

  localparam logic [CRC_W-1:0] CRC_SEED     = '1;
  localparam logic [CRC_W-1:0] CRC_POLY_REV = 32'hEDB8_8320;

  // register indices
  localparam logic [CFG_AW-1:0] CFG_STN_LOW  = 3'd0;
  localparam logic [CFG_AW-1:0] CFG_STN_HIGH = 3'd1;
  localparam logic [CFG_AW-1:0] CFG_HASH_LO  = 3'd2;
  localparam logic [CFG_AW-1:0] CFG_HASH_HI  = 3'd3;
  localparam logic [CFG_AW-1:0] CFG_CTRL     = 3'd4;
  localparam logic [CFG_AW-1:0] CFG_CH_MASK  = 3'd5;

  // field positions
  localparam int unsigned STN_VALID_BIT = 16;
  localparam int unsigned STN_MATCH_BIT = 17;
  localparam int unsigned CTRL_BC_BIT   = 0;
  localparam int unsigned CTRL_ALL_BIT  = 1;

  typedef enum logic [2:0] {
    RSN_REJECT   = 3'd0,
    RSN_UNICAST  = 3'd1,
    RSN_BCAST    = 3'd2,
    RSN_MC_HASH  = 3'd3,
    RSN_COPY_ALL = 3'd4
  } rxaf_reason_e;

  // one byte of a reflected CRC-32 update, least significant data bit first
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c_in,
                                                input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] c;
    c = c_in;
    for (int i = 0; i < int'(BYTE_W); i++) begin
      if (c[0] ^ d[i]) c = (c >> 1) ^ CRC_POLY_REV;
      else             c = c >> 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/rxaf_cfg.sv
module rxaf_cfg
  import rxaf_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CFG_AW-1:0] addr,
  input  logic [CFG_DW-1:0] wdata,
  output logic [ADDR_W-1:0] stn_addr,
  output logic              stn_valid,
  output logic              stn_match,
  output logic [HASH_W-1:0] hash_tbl,
  output logic              bc_en,
  output logic              copy_all,
  output logic [NUM_CH-1:0] ch_en
);
  localparam int unsigned LOW_BYTES_W = 32;
  localparam int unsigned HIGH_BYTES_W = ADDR_W - LOW_BYTES_W;

  logic [LOW_BYTES_W-1:0]  stn_low_q;
  logic [HIGH_BYTES_W-1:0] stn_high_q;
  logic                    stn_valid_q, stn_match_q;
  logic [CFG_DW-1:0]       hash_lo_q, hash_hi_q;
  logic                    bc_q, all_q;
  logic [NUM_CH-1:0]       ch_q;

  logic en_low, en_high, en_hlo, en_hhi, en_ctrl, en_ch;

  always_comb begin
    en_low  = we && (addr == CFG_STN_LOW);
    en_high = we && (addr == CFG_STN_HIGH);
    en_hlo  = we && (addr == CFG_HASH_LO);
    en_hhi  = we && (addr == CFG_HASH_HI);
    en_ctrl = we && (addr == CFG_CTRL);
    en_ch   = we && (addr == CFG_CH_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stn_low_q <= '0;
    else if (en_low) stn_low_q <= wdata[LOW_BYTES_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stn_high_q  <= '0;
      stn_valid_q <= 1'b0;
      stn_match_q <= 1'b0;
    end else if (en_high) begin
      stn_high_q  <= wdata[HIGH_BYTES_W-1:0];
      stn_valid_q <= wdata[STN_VALID_BIT];
      stn_match_q <= wdata[STN_MATCH_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hash_lo_q <= '0;
    else if (en_hlo) hash_lo_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hash_hi_q <= '0;
    else if (en_hhi) hash_hi_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc_q  <= 1'b0;
      all_q <= 1'b0;
    end else if (en_ctrl) begin
      bc_q  <= wdata[CTRL_BC_BIT];
      all_q <= wdata[CTRL_ALL_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ch_q <= '0;
    else if (en_ch) ch_q <= wdata[NUM_CH-1:0];
  end

  assign stn_addr  = {stn_high_q, stn_low_q};
  assign stn_valid = stn_valid_q;
  assign stn_match = stn_match_q;
  assign hash_tbl  = {hash_hi_q, hash_lo_q};
  assign bc_en     = bc_q;
  assign copy_all  = all_q;
  assign ch_en     = ch_q;

  // R2: a write to the low station register lands with byte 0 in the low bits
  a_r2_low_bytes_load: assert property (@(posedge clk) disable iff (!rst_n)
    en_low |=> stn_addr[LOW_BYTES_W-1:0] == $past(wdata[LOW_BYTES_W-1:0]));
endmodule

// File: rtl/rxaf_collect.sv
module rxaf_collect
  import rxaf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic [BYTE_W-1:0] rx_data,
  output logic [HEAD_W-1:0] head_bytes,
  output logic [CRC_W-1:0]  head_crc,
  output logic              fin_stb,
  output logic              short_stb
);
  localparam int unsigned HEAD_N = ADDR_BYTES - 1;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(ADDR_BYTES - 1);

  logic             active_q, active_d;
  logic [POS_W-1:0] cnt_q, cnt_d, pos;
  logic [CRC_W-1:0] crc_q, crc_d;
  logic             take, store, ending;

  always_comb begin
    take      = rx_valid && (rx_sof || active_q);
    pos       = rx_sof ? '0 : cnt_q;
    fin_stb   = take && (pos == LAST_POS);
    short_stb = take && rx_eof && (pos < LAST_POS);
    store     = take && (pos < LAST_POS);
    ending    = fin_stb || rx_eof;
    active_d  = !ending;
    cnt_d     = ending ? '0 : pos + POS_W'(1);
    crc_d     = crc_step(rx_sof ? CRC_SEED : crc_q, rx_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (take) begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else if (store) crc_q <= crc_d;
  end

  for (genvar k = 0; k < HEAD_N; k++) begin : g_head
    localparam logic [POS_W-1:0] K_POS = POS_W'(k);
    logic [BYTE_W-1:0] hb_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hb_q <= '0;
      else if (store && (pos == K_POS)) hb_q <= rx_data;
    end
    assign head_bytes[k*BYTE_W +: BYTE_W] = hb_q;
  end

  assign head_crc = crc_q;

  // R7: the byte counter never passes the last header position
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < LAST_POS || (cnt_q == LAST_POS && active_q));

  // R9: a start marker always restarts collection at position one
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_sof && !rx_eof) |=> (active_q && cnt_q == POS_W'(1)));
endmodule

// File: rtl/rxaf_decide.sv
module rxaf_decide
  import rxaf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic [HEAD_W-1:0] head_bytes,
  input  logic [CRC_W-1:0]  head_crc,
  input  logic              fin_stb,
  input  logic              short_stb,
  input  logic [ADDR_W-1:0] stn_addr,
  input  logic              stn_valid,
  input  logic              stn_match,
  input  logic              uc_ch0_en,
  input  logic [HASH_W-1:0] hash_tbl,
  input  logic              bc_en,
  input  logic              copy_all,
  output logic              res_valid,
  output logic              res_accept,
  output logic [2:0]        res_reason
);
  logic [ADDR_W-1:0]     dest;
  logic [CRC_W-1:0]      crc_fin;
  logic [HASH_IDX_W-1:0] hidx;
  logic                  is_bc, is_mc, uc_hit, bc_hit, mc_hit;
  logic                  valid_d, accept_d, upd;
  rxaf_reason_e          reason_d, reason_q;
  logic                  valid_q, accept_q;

  always_comb begin
    dest    = {rx_data, head_bytes};
    crc_fin = crc_step(head_crc, rx_data);
    hidx    = crc_fin[CRC_W-1 -: HASH_IDX_W];
    is_bc   = &dest;
    is_mc   = dest[0] && !is_bc;
    uc_hit  = (dest == stn_addr) && stn_valid && stn_match && uc_ch0_en;
    bc_hit  = is_bc && bc_en;
    mc_hit  = is_mc && hash_tbl[hidx];

    if (!fin_stb)     reason_d = RSN_REJECT;
    else if (uc_hit)  reason_d = RSN_UNICAST;
    else if (bc_hit)  reason_d = RSN_BCAST;
    else if (mc_hit)  reason_d = RSN_MC_HASH;
    else if (copy_all) reason_d = RSN_COPY_ALL;
    else              reason_d = RSN_REJECT;

    accept_d = fin_stb && (uc_hit || bc_hit || mc_hit || copy_all);
    valid_d  = fin_stb || short_stb;
    upd      = valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept_q <= 1'b0;
      reason_q <= RSN_REJECT;
    end else if (upd) begin
      accept_q <= accept_d;
      reason_q <= reason_d;
    end
  end

  assign res_valid  = valid_q;
  assign res_accept = accept_q;
  assign res_reason = reason_q;

  // R10: accept flag agrees with a non-zero reason
  a_r10_accept_reason: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_accept == (res_reason != RSN_REJECT)));

  // R8: a truncated header is always rejected one clock later
  a_r8_short_reject: assert property (@(posedge clk) disable iff (!rst_n)
    short_stb |=> (res_valid && !res_accept && res_reason == RSN_REJECT));

  // R7: a verdict only follows a final or short byte
  a_r7_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(fin_stb || short_stb));

  // R4: broadcast reason only with broadcast enabled
  a_r4_bcast_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_reason == RSN_BCAST) |-> $past(bc_en));
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxaf_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              res_valid,
  output logic              res_accept,
  output logic [2:0]        res_reason
);
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [ADDR_W-1:0] stn_addr;
  logic              stn_valid, stn_match, bc_en, copy_all;
  logic [HASH_W-1:0] hash_tbl;
  logic [NUM_CH-1:0] ch_en;
  logic [HEAD_W-1:0] head_bytes;
  logic [CRC_W-1:0]  head_crc;
  logic              fin_stb, short_stb;

  rxaf_cfg #(.NUM_CH(NUM_CH)) u_cfg (
    .clk(clk), .rst_n(rst_sync_q), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .stn_addr(stn_addr), .stn_valid(stn_valid), .stn_match(stn_match),
    .hash_tbl(hash_tbl), .bc_en(bc_en), .copy_all(copy_all), .ch_en(ch_en)
  );

  rxaf_collect u_collect (
    .clk(clk), .rst_n(rst_sync_q), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_data(rx_data), .head_bytes(head_bytes),
    .head_crc(head_crc), .fin_stb(fin_stb), .short_stb(short_stb)
  );

  rxaf_decide u_decide (
    .clk(clk), .rst_n(rst_sync_q), .rx_data(rx_data), .head_bytes(head_bytes),
    .head_crc(head_crc), .fin_stb(fin_stb), .short_stb(short_stb),
    .stn_addr(stn_addr), .stn_valid(stn_valid), .stn_match(stn_match),
    .uc_ch0_en(ch_en[0]), .hash_tbl(hash_tbl), .bc_en(bc_en),
    .copy_all(copy_all), .res_valid(res_valid), .res_accept(res_accept),
    .res_reason(res_reason)
  );

  // R3: unicast reason requires valid, match-enable and channel 0 enable
  a_r3_unicast_gates: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (res_valid && res_reason == RSN_UNICAST) |-> $past(stn_valid && stn_match && ch_en[0]));
endmodule

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        rx_valid, rx_sof, rx_eof;
  logic [7:0]  rx_data;
  logic        res_valid, res_accept;
  logic [2:0]  res_reason;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // shadow configuration
  logic [47:0] stn;
  logic        s_valid, s_match, s_bc, s_all;
  logic [63:0] s_hash;
  logic [7:0]  s_ch;

  always #10 clk = ~clk;

  rx_addr_filter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_data(rx_data), .res_valid(res_valid), .res_accept(res_accept),
    .res_reason(res_reason)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cfg_wr(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic apply_cfg();
    cfg_wr(3'd0, stn[31:0]);
    cfg_wr(3'd1, {14'd0, s_match, s_valid, stn[47:32]});
    cfg_wr(3'd2, s_hash[31:0]);
    cfg_wr(3'd3, s_hash[63:32]);
    cfg_wr(3'd4, {30'd0, s_all, s_bc});
    cfg_wr(3'd5, {24'd0, s_ch});
  endtask

  // bit-serial CRC over the 48 address bits, byte 0 first, LSB first
  function automatic logic [5:0] bench_idx(input logic [47:0] d);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int b = 0; b < 48; b++) begin
      logic fb = c[0] ^ d[b];
      c = {1'b0, c[31:1]};
      if (fb) c = c ^ 32'hEDB8_8320;
    end
    return c[31:26];
  endfunction

  function automatic logic [2:0] exp_reason(input logic [47:0] d);
    if (d == stn && s_valid && s_match && s_ch[0]) return 3'd1;
    if (&d && s_bc) return 3'd2;
    if (d[0] && !(&d) && s_hash[bench_idx(d)]) return 3'd3;
    if (s_all) return 3'd4;
    return 3'd0;
  endfunction

  function automatic string tag_of(input logic [2:0] r);
    case (r)
      3'd1: return "R2";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R3";
    endcase
  endfunction

  task automatic send_frame(input logic [47:0] d, input int len,
                            input logic [2:0] er, input string req);
    for (int k = 0; k < len; k++) begin
      rx_valid = 1'b1; rx_sof = (k == 0); rx_eof = (k == len - 1);
      rx_data  = (k < 6) ? d[8*k +: 8] : 8'(k * 7 + 3);
      @(negedge clk);
      if (k == 5 || (len < 6 && k == len - 1)) begin
        check(req, res_valid, 1);
        check(req, res_reason, er);
        check("R10", res_accept, er != 3'd0);
      end else begin
        check("R7", res_valid, 0);
      end
    end
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    @(negedge clk);
    check("R7", res_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [47:0] bcast, mc_hit, mc_miss, uc_other;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = '0;
    repeat (3) @(negedge clk);
    check("R1", res_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", res_valid, 0);

    stn = {8'h55, 8'h44, 8'h33, 8'h22, 8'h11, 8'h02};
    bcast = '1;
    // R1: cleared configuration rejects everything
    send_frame(stn, 8, 3'd0, "R1");
    send_frame(bcast, 8, 3'd0, "R1");

    mc_hit = {8'h07, 8'h00, 8'h00, 8'h5e, 8'h00, 8'h01};
    mc_miss = mc_hit;
    for (int j = 8; j < 255; j++) begin
      mc_miss[47:40] = 8'(j);
      if (bench_idx(mc_miss) != bench_idx(mc_hit)) break;
    end
    uc_other = stn ^ {8'h01, 40'd0};

    // sweep of all enable combinations against five destination kinds
    for (int m = 0; m < 32; m++) begin
      s_bc = m[0]; s_all = m[1]; s_ch = {7'd0, m[2]}; s_valid = m[3]; s_match = m[4];
      s_hash = 64'd1 << bench_idx(mc_hit);
      apply_cfg();
      send_frame(stn,      8, exp_reason(stn),      tag_of(exp_reason(stn)));
      send_frame(uc_other, 7, exp_reason(uc_other), tag_of(exp_reason(uc_other)));
      send_frame(bcast,    6, exp_reason(bcast),    tag_of(exp_reason(bcast)));
      send_frame(mc_hit,   9, exp_reason(mc_hit),   tag_of(exp_reason(mc_hit)));
      send_frame(mc_miss,  8, exp_reason(mc_miss),  "R5");
    end

    // R2: each byte position of the station address matters
    s_bc = 0; s_all = 0; s_ch = 8'h01; s_valid = 1; s_match = 1; s_hash = '0;
    apply_cfg();
    for (int k = 0; k < 6; k++) begin
      logic [47:0] d = stn ^ (48'h80 << (8 * k));
      send_frame(d, 8, 3'd0, "R2");
    end
    send_frame(stn, 8, 3'd1, "R2");

    // R11: channel bits other than 0 do not enable unicast
    s_ch = 8'hFE; apply_cfg();
    send_frame(stn, 8, 3'd0, "R11");

    // R5: each hash bit alone, against 64 multicast destinations
    s_ch = 8'h00; s_valid = 0; s_match = 0;
    for (int j = 0; j < 64; j++) begin
      logic [47:0] d = {8'(j * 5), 8'(j), 8'h00, 8'h5e, 8'h00, 8'h01};
      s_hash = 64'd1 << j;
      cfg_wr(3'd2, s_hash[31:0]);
      cfg_wr(3'd3, s_hash[63:32]);
      send_frame(d, 7, (bench_idx(d) == 6'(j)) ? 3'd3 : 3'd0, "R5");
    end
    s_hash = '1; apply_cfg();
    send_frame(mc_miss, 8, 3'd3, "R5");
    send_frame(stn, 8, 3'd0, "R5");

    // R8: short frames rejected even under copy-all
    s_all = 1; s_hash = '0; apply_cfg();
    for (int n = 1; n < 6; n++) send_frame(bcast, n, 3'd0, "R8");
    send_frame(uc_other, 6, 3'd4, "R6");

    // R9: restart mid-header yields only the new frame's result
    for (int k = 0; k < 3; k++) begin
      rx_valid = 1'b1; rx_sof = (k == 0); rx_eof = 1'b0; rx_data = stn[8*k +: 8];
      @(negedge clk);
      check("R9", res_valid, 0);
    end
    s_all = 0; s_bc = 1; cfg_wr(3'd4, 32'h1);
    check("R9", res_valid, 0);
    send_frame(bcast, 8, 3'd2, "R9");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule